// File: doc/BRIEF.md
# Masked Pin-Match Interrupt Generator

This block produces the interrupt for one bit-programmed port of a general-purpose I/O unit. Software writes a short run of control bytes: a condition byte that chooses which pin level counts as a match and whether any or all monitored lines must match, an optional mask byte, and a separate master enable byte. The block brings the port lines through a synchronizer, compares the lines that are not masked against the condition, and holds a level-sensitive pending flag that follows the comparison. The pending flag is always visible as a status bit. The interrupt pin itself is shown as the enable of an active-low open-drain pull-down, so several of these blocks can share one wired interrupt line.

A condition byte with its "mask follows" flag set makes the next control write load the mask and not a new condition. A mask with every bit set would leave nothing to watch. Such a mask is refused: the old mask stays in place and an error flag goes up. Rewriting the condition while the interrupt is enabled blanks the pull-down for one cycle, so a half-changed condition cannot cause a spurious pulse.

The CPU bus decode and the port direction logic live elsewhere. The block receives decoded write strobes, the write data, the raw pin values and an active-low clear.

Top module: `pin_match_irq`

## Requirements
- R1: When clear is low, the pending flag, the pull-down enable and the error flag go to 0, the interrupt is disabled, every mask bit goes to 0 (all lines monitored), and the condition becomes "any line at 0".
- R2: Condition byte bit 0 = 1 selects active-high matching: a line matches when it is 1. With bit 1 = 0 (any mode), pending is 1 when at least one unmasked line matches.
- R3: Condition byte bit 1 = 1 selects all mode: pending is 1 only when every unmasked line matches.
- R4: Condition byte bit 0 = 0 selects active-low matching: a line matches when it is 0. This holds in both any mode and all mode.
- R5: When condition byte bit 4 is 1, the next control write loads the mask. When bit 4 is 0, the next control write is taken as a new condition byte and the mask is left unchanged.
- R6: A mask bit of 1 removes its line from the comparison. A mask bit of 0 keeps the line monitored.
- R7: A mask write whose value is all ones is refused. The previous mask is kept and the error flag is set. The next accepted mask write clears the error flag. After a refused mask, the next control write is again a condition byte.
- R8: An enable-byte write with bit 0 = 1 enables the pull-down, and one with bit 0 = 0 disables it. The pull-down is asserted only while the block is enabled and pending is 1. The pending status output reflects the condition even while the block is disabled.
- R9: A change on the pins first shows on the pending output after the third rising clock edge: two synchronizer stages, then the pending register.
- R10: A condition-byte write made while the interrupt is enabled forces the pull-down off in the cycle after the write edge. In the following cycle the pull-down again follows pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| clr_ni | input | 1 | Asynchronous clear, active low |
| cmd_wr_i | input | 1 | Strobe for a control write (condition byte or mask byte) |
| en_wr_i | input | 1 | Strobe for an enable/disable byte write |
| wdata_i | input | DW (8) | Write data for either strobe |
| pins_i | input | W (8) | Raw port line levels |
| pending_o | output | 1 | Interrupt pending status bit |
| mask_err_o | output | 1 | Set when an all-ones mask has been refused |
| irq_pd_o | output | 1 | Open-drain pull-down enable; 1 pulls the shared active-low line low |

## Verification
The assertions assume that the two write strobes are never high in the same cycle and that they change only away from the active edge. They also assume that the clear is held long enough for the synchronizer to be flushed. The bench drives every input on the falling edge and raises at most one strobe per write task. It holds clear low across several edges and lets the pins settle before it reads the outputs, except in the latency test, which counts edges on purpose.

// File: rtl/pmi_pkg.sv
package pmi_pkg;

    typedef enum logic {
        CMB_ANY = 1'b0,
        CMB_ALL = 1'b1
    } combine_e;

    typedef struct packed {
        logic     active_high;
        combine_e combine;
    } cond_t;

    localparam int CB_POL_BIT      = 0;
    localparam int CB_CMB_BIT      = 1;
    localparam int CB_MASKNEXT_BIT = 4;
    localparam int EN_BIT          = 0;

endpackage

// File: rtl/pmi_sync.sv
module pmi_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         clr_ni,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i or negedge clr_ni) begin
            if (!clr_ni) begin
                stg_q[g] <= '0;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign sync_o = stg_q[LAST];

endmodule

// File: rtl/pmi_ctrl.sv
module pmi_ctrl
    import pmi_pkg::*;
#(
    parameter int W  = 8,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          clr_ni,
    input  logic          cmd_wr_i,
    input  logic          en_wr_i,
    input  logic [DW-1:0] wdata_i,
    output cond_t         cond_o,
    output logic [W-1:0]  mask_o,
    output logic          enable_o,
    output logic          await_mask_o,
    output logic          mask_err_o,
    output logic          hold_o
);
    localparam logic [W-1:0] ALL_MASKED = {W{1'b1}};

    typedef struct packed {
        cond_t        cond;
        logic [W-1:0] mask;
        logic         en;
        logic         await_mask;
        logic         err;
        logic         hold;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [W-1:0] mask_val;
    logic         is_cmd_wr;
    logic         is_mask_wr;

    assign mask_val   = wdata_i[W-1:0];
    assign is_cmd_wr  = cmd_wr_i && !st_q.await_mask;
    assign is_mask_wr = cmd_wr_i && st_q.await_mask;

    always_comb begin
        st_d      = st_q;
        st_d.hold = is_cmd_wr && st_q.en;
        if (is_cmd_wr) begin
            st_d.cond.active_high = wdata_i[CB_POL_BIT];
            st_d.cond.combine     = combine_e'(wdata_i[CB_CMB_BIT]);
            st_d.await_mask       = wdata_i[CB_MASKNEXT_BIT];
        end
        if (is_mask_wr) begin
            st_d.await_mask = 1'b0;
            if (mask_val == ALL_MASKED) begin
                st_d.err = 1'b1;
            end else begin
                st_d.mask = mask_val;
                st_d.err  = 1'b0;
            end
        end
        if (en_wr_i) begin
            st_d.en = wdata_i[EN_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cond_o       = st_q.cond;
    assign mask_o       = st_q.mask;
    assign enable_o     = st_q.en;
    assign await_mask_o = st_q.await_mask;
    assign mask_err_o   = st_q.err;
    assign hold_o       = st_q.hold;

    // R5: a legal mask byte is taken and the error flag drops
    p_mask_load_r5: assert property (@(posedge clk_i) disable iff (!clr_ni)
        (cmd_wr_i && await_mask_o && (wdata_i[W-1:0] != ALL_MASKED))
        |=> (mask_o == $past(wdata_i[W-1:0])) && !mask_err_o && !await_mask_o);

    // R5: a condition byte never touches the mask
    p_cmd_keeps_mask_r5: assert property (@(posedge clk_i) disable iff (!clr_ni)
        (cmd_wr_i && !await_mask_o) |=> $stable(mask_o));

    // R7: all-ones mask refused, error raised, sequence returns to commands
    p_ff_reject_r7: assert property (@(posedge clk_i) disable iff (!clr_ni)
        (cmd_wr_i && await_mask_o && (wdata_i[W-1:0] == ALL_MASKED))
        |=> $stable(mask_o) && mask_err_o && !await_mask_o);

endmodule

// File: rtl/pmi_eval.sv
module pmi_eval
    import pmi_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] lines_i,
    input  cond_t        cond_i,
    input  logic [W-1:0] mask_i,
    output logic         any_o,
    output logic         all_o,
    output logic         hit_o
);
    logic [W-1:0] match;
    logic [W-1:0] watched;
    logic [W-1:0] satisfied;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign match[b]     = ~(lines_i[b] ^ cond_i.active_high);
        assign watched[b]   = match[b] & ~mask_i[b];
        assign satisfied[b] = match[b] | mask_i[b];
    end

    always_comb begin
        any_o = |watched;
        all_o = &satisfied;
        unique case (cond_i.combine)
            CMB_ALL: hit_o = all_o;
            default: hit_o = any_o;
        endcase
    end

endmodule

// File: rtl/pin_match_irq.sv
module pin_match_irq
    import pmi_pkg::*;
#(
    parameter int W           = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          clr_ni,
    input  logic          cmd_wr_i,
    input  logic          en_wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [W-1:0]  pins_i,
    output logic          pending_o,
    output logic          mask_err_o,
    output logic          irq_pd_o
);
    typedef struct packed {
        logic pending;
    } top_t;

    top_t st_d, st_q;

    logic [W-1:0] lines_s;
    cond_t        cond;
    logic [W-1:0] mask;
    logic         enable;
    logic         await_mask;
    logic         hold;
    logic         any_hit;
    logic         all_hit;
    logic         hit;

    pmi_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .clr_ni (clr_ni),
        .raw_i  (pins_i),
        .sync_o (lines_s)
    );

    pmi_ctrl #(.W(W), .DW(DW)) u_ctrl (
        .clk_i        (clk_i),
        .clr_ni       (clr_ni),
        .cmd_wr_i     (cmd_wr_i),
        .en_wr_i      (en_wr_i),
        .wdata_i      (wdata_i),
        .cond_o       (cond),
        .mask_o       (mask),
        .enable_o     (enable),
        .await_mask_o (await_mask),
        .mask_err_o   (mask_err_o),
        .hold_o       (hold)
    );

    pmi_eval #(.W(W)) u_eval (
        .lines_i (lines_s),
        .cond_i  (cond),
        .mask_i  (mask),
        .any_o   (any_hit),
        .all_o   (all_hit),
        .hit_o   (hit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pending = hit;
    end

    always_ff @(posedge clk_i or negedge clr_ni) begin
        if (!clr_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pending;
    assign irq_pd_o  = enable && st_q.pending && !hold;

    // R8: the pull-down acts only when enabled and pending
    p_pd_gated_r8: assert property (@(posedge clk_i) disable iff (!clr_ni)
        irq_pd_o |-> (enable && pending_o));

    // R10: a condition rewrite while enabled blanks the next cycle
    p_hold_blank_r10: assert property (@(posedge clk_i) disable iff (!clr_ni)
        (cmd_wr_i && !await_mask && enable) |=> !irq_pd_o);

    // R9: pending follows the evaluated condition one edge later
    p_pending_follows_r9: assert property (@(posedge clk_i) disable iff (!clr_ni)
        1'b1 |=> (pending_o == $past(hit)));

    // R3: with at least one line watched, all-match implies any-match
    p_all_in_any_r3: assert property (@(posedge clk_i) disable iff (!clr_ni)
        all_hit |-> any_hit);

endmodule

// File: tb/pin_match_irq_tb.sv
`timescale 1ns/1ps
module pin_match_irq_tb;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic       en_wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] pins = '0;
    logic       pending;
    logic       mask_err;
    logic       irq_pd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pin_match_irq u_dut (
        .clk_i      (clk),
        .clr_ni     (clr_n),
        .cmd_wr_i   (cmd_wr),
        .en_wr_i    (en_wr),
        .wdata_i    (wdata),
        .pins_i     (pins),
        .pending_o  (pending),
        .mask_err_o (mask_err),
        .irq_pd_o   (irq_pd)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_n = 1'b0;
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
    endtask

    task automatic ctl(input logic [7:0] d);
        @(negedge clk);
        cmd_wr = 1'b1;
        wdata  = d;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic set_en(input logic on);
        @(negedge clk);
        en_wr = 1'b1;
        wdata = {7'b0, on};
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        pins = 8'hFF;
        do_clear();
        check("R1", "pending after clear", pending, 1'b0);
        check("R1", "pull-down after clear", irq_pd, 1'b0);
        check("R1", "error after clear", mask_err, 1'b0);
        drive(8'hFF);
        check("R1", "default any-at-0, all pins high", pending, 1'b0);
        drive(8'hFB);
        check("R1", "default any-at-0, one pin low", pending, 1'b1);
        check("R1", "disabled after clear", irq_pd, 1'b0);
    endtask

    task automatic t_clear_unmasks();
        ctl(8'h13);
        ctl(8'h01);
        drive(8'hFE);
        check("R6", "line 0 masked in all-high", pending, 1'b1);
        do_clear();
        ctl(8'h03);
        drive(8'hFE);
        check("R1", "clear unmasked line 0", pending, 1'b0);
    endtask

    task automatic t_or_high();
        ctl(8'h01);
        drive(8'h00);
        check("R2", "any-high none set", pending, 1'b0);
        drive(8'h10);
        check("R2", "any-high bit4 set", pending, 1'b1);
        drive(8'h80);
        check("R2", "any-high bit7 set", pending, 1'b1);
    endtask

    task automatic t_and_high();
        ctl(8'h03);
        drive(8'hFE);
        check("R3", "all-high one low", pending, 1'b0);
        drive(8'hFF);
        check("R3", "all-high all set", pending, 1'b1);
    endtask

    task automatic t_low();
        ctl(8'h00);
        drive(8'hFF);
        check("R4", "any-low none low", pending, 1'b0);
        drive(8'hF7);
        check("R4", "any-low bit3 low", pending, 1'b1);
        ctl(8'h02);
        drive(8'h01);
        check("R4", "all-low bit0 high", pending, 1'b0);
        drive(8'h00);
        check("R4", "all-low all low", pending, 1'b1);
    endtask

    task automatic t_mask_seq();
        ctl(8'h13);
        ctl(8'h0F);
        drive(8'hF0);
        check("R6", "all-high low nibble masked", pending, 1'b1);
        drive(8'h70);
        check("R6", "all-high bit7 watched low", pending, 1'b0);
        ctl(8'h01);
        ctl(8'h03);
        drive(8'hF0);
        check("R5", "second write taken as condition", pending, 1'b1);
        ctl(8'h01);
        drive(8'h0F);
        check("R6", "any-high masked lines ignored", pending, 1'b0);
    endtask

    task automatic t_ff_reject();
        ctl(8'h13);
        ctl(8'hFF);
        check("R7", "error after all-ones mask", mask_err, 1'b1);
        drive(8'h0F);
        check("R7", "old mask kept", pending, 1'b0);
        ctl(8'h03);
        drive(8'h0F);
        check("R7", "write after refusal is a condition", pending, 1'b0);
        ctl(8'h13);
        ctl(8'h00);
        check("R7", "error cleared by legal mask", mask_err, 1'b0);
        drive(8'hFE);
        check("R7", "legal mask applied", pending, 1'b0);
    endtask

    task automatic t_enable();
        ctl(8'h01);
        drive(8'h01);
        check("R8", "pending while disabled", pending, 1'b1);
        check("R8", "no pull-down while disabled", irq_pd, 1'b0);
        set_en(1'b1);
        check("R8", "pull-down when enabled", irq_pd, 1'b1);
        drive(8'h00);
        check("R8", "no pull-down when not pending", irq_pd, 1'b0);
        drive(8'h02);
        set_en(1'b0);
        check("R8", "disable drops pull-down", irq_pd, 1'b0);
        check("R8", "status kept when disabled", pending, 1'b1);
    endtask

    task automatic t_latency();
        ctl(8'h01);
        drive(8'h00);
        @(negedge clk);
        pins = 8'h40;
        @(negedge clk);
        check("R9", "after edge 1", pending, 1'b0);
        @(negedge clk);
        check("R9", "after edge 2", pending, 1'b0);
        @(negedge clk);
        check("R9", "after edge 3", pending, 1'b1);
    endtask

    task automatic t_hold();
        ctl(8'h01);
        drive(8'h01);
        set_en(1'b1);
        check("R10", "pull-down before rewrite", irq_pd, 1'b1);
        @(negedge clk);
        cmd_wr = 1'b1;
        wdata  = 8'h01;
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R10", "blanked after rewrite", irq_pd, 1'b0);
        check("R10", "pending unaffected", pending, 1'b1);
        @(negedge clk);
        check("R10", "restored next cycle", irq_pd, 1'b1);
        set_en(1'b0);
    endtask

    initial begin
        t_reset();
        t_clear_unmasks();
        t_or_high();
        t_and_high();
        t_low();
        t_mask_seq();
        t_ff_reject();
        t_enable();
        t_latency();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule